// File: doc/BRIEF.md
# Bus Hold/Acknowledge Ownership Controller

This controller decides whether the local processor side or an outside master owns a shared expansion bus. It produces one output-enable per group of bus signals that must be tristated during a hand-over: the byte-enable/address group, the address strobe, the read/write line and the burst-last line. It also produces a grant flag that tells the local bus master it may start transfers. The pad drivers, the transfer protocol and any synchronisers sit outside the block. The hold and acknowledge inputs are taken to be synchronous to `clk` already.

The block has two roles, and a mode input picks one while reset is asserted. In the granting role (internal arbiter), an outside requester raises a hold request. The block withdraws the local grant and waits a minimum number of cycles. It also waits until no local transfer is pending. It then tristates the bus and raises acknowledge. When the request falls, the block waits a minimum spacing, drops acknowledge and then drives the bus again. In the requesting role (external arbiter), the block raises its own hold request when the local side wants the bus. It drives the bus a fixed number of cycles after an acknowledge arrives. On hand-back it tristates the bus before it drops its request.

Top module: `bus_own_ctrl`

## Requirements
- R1: `mode_ext_i` is captured on every clock edge while `rst_n` is low and held after reset (0 = granting role, 1 = requesting role). Right after reset, the granting role shows all `bus_oe_o` bits 1, `grant_o` 1 and `hack_o` 0. The requesting role shows all `bus_oe_o` bits 0, `grant_o` 0 and `hreq_o` 0. All bits of `bus_oe_o` always carry the same value.
- R2: In the granting role, `grant_o` goes low after the first clock edge at which `hreq_i` is sampled high while the block owns the bus. `bus_oe_o` stays high after that edge.
- R3: In the granting role with no pending transfer, `bus_oe_o` goes low after the clock edge REL_DLY (default 3) edges after the edge that first sampled `hreq_i` high.
- R4: In the granting role, while `xfer_pend_i` is high the bus is not released. Once the REL_DLY spacing has passed, release follows the first edge at which `xfer_pend_i` is sampled low.
- R5: In the granting role, `hack_o` rises ACK_DLY (default 1) edges after the edge that released the bus.
- R6: In the granting role, `hack_o` stays high while `hreq_i` stays high. It falls RET_DLY (default 3) edges after the edge that first sampled `hreq_i` low. `bus_oe_o` and `grant_o` return high REDRV_DLY (default 1) edges after `hack_o` falls.
- R7: `hack_o` is never high in a cycle where any `bus_oe_o` bit or `grant_o` is high.
- R8: In the granting role, `hack_i` and `loc_want_i` have no effect, and `hreq_o` stays 0.
- R9: In the requesting role, `hreq_o` rises after the edge that samples `loc_want_i` high with `hack_i` low. While `hack_i` is still high from an earlier hand-over, no new request is raised.
- R10: In the requesting role, `bus_oe_o` and `grant_o` rise EXT_DRV_DLY (default 2) edges after the edge that first samples `hack_i` high while requesting.
- R11: In the requesting role, the owned bus is kept until an edge samples both `loc_want_i` and `xfer_pend_i` low. `bus_oe_o` and `grant_o` fall after that edge, and `hreq_o` falls EXT_DROP_DLY (default 1) edges later.
- R12: In the requesting role, `hreq_i` has no effect and `hack_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; the mode is captured while it is low |
| mode_ext_i | input | 1 | Role select: 0 grants the bus, 1 requests it |
| xfer_pend_i | input | 1 | A local bus transfer is in flight |
| loc_want_i | input | 1 | Local side wants the bus (requesting role) |
| hreq_i | input | 1 | Hold request from an outside requester (granting role) |
| hack_o | output | 1 | Hold acknowledge to the outside requester (granting role) |
| hreq_o | output | 1 | Hold request to an outside arbiter (requesting role) |
| hack_i | input | 1 | Hold acknowledge from the outside arbiter (requesting role) |
| bus_oe_o | output | NGRP | Output enable for each tristated bus group |
| grant_o | output | 1 | Local master may use the bus |

## Verification
Every output is decoded from registered state, so a change to an input that is sampled at edge k shows up in the cycle after edge k. The bench drives inputs on the falling edge and advances one rising edge at a time. It then samples on the following falling edge, which means the number of steps it waits equals the edge count in the requirement. Examples: the release comes 3 steps after the request, the acknowledge 1 step after that, the hand-back drop 3 steps after the request falls, and, in the requesting role, bus drive 2 steps after the acknowledge. For the windows that must not change (pending transfers, an acknowledge still held high), the bench checks the output on each step inside the window, not only at its end.

// File: rtl/bown_pkg.sv
package bown_pkg;

    typedef enum logic [2:0] {
        I_OWN,
        I_HOLD,
        I_REL,
        I_GNT,
        I_RET,
        I_BACK
    } int_st_e;

    typedef enum logic [2:0] {
        X_IDLE,
        X_REQ,
        X_WAIT,
        X_OWN,
        X_REL
    } ext_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bown_int_fsm.sv
module bown_int_fsm
    import bown_pkg::*;
#(
    parameter int REL_DLY   = 3,
    parameter int ACK_DLY   = 1,
    parameter int RET_DLY   = 3,
    parameter int REDRV_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hreq_i,
    input  logic pend_i,
    output logic oe_o,
    output logic grant_o,
    output logic hack_o
);

    localparam int MAXD = max2(max2(REL_DLY, ACK_DLY), max2(RET_DLY, REDRV_DLY));
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] REL_C   = CW'(REL_DLY);
    localparam logic [CW-1:0] ACK_C   = CW'(ACK_DLY);
    localparam logic [CW-1:0] RET_C   = CW'(RET_DLY);
    localparam logic [CW-1:0] REDRV_C = CW'(REDRV_DLY);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    typedef struct packed {
        int_st_e       st;
        logic [CW-1:0] cnt;
    } int_regs_t;

    localparam int_regs_t RST_V = '{st: I_OWN, cnt: '0};

    int_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            I_OWN: begin
                if (hreq_i) begin
                    r_d.st  = I_HOLD;
                    r_d.cnt = ONE_C;
                end
            end
            I_HOLD: begin
                if (r_q.cnt >= REL_C) begin
                    if (!pend_i) begin
                        r_d.st  = I_REL;
                        r_d.cnt = ONE_C;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + ONE_C;
                end
            end
            I_REL: begin
                if (r_q.cnt >= ACK_C) r_d.st = I_GNT;
                else                  r_d.cnt = r_q.cnt + ONE_C;
            end
            I_GNT: begin
                if (!hreq_i) begin
                    r_d.st  = I_RET;
                    r_d.cnt = ONE_C;
                end
            end
            I_RET: begin
                if (r_q.cnt >= RET_C) begin
                    r_d.st  = I_BACK;
                    r_d.cnt = ONE_C;
                end else begin
                    r_d.cnt = r_q.cnt + ONE_C;
                end
            end
            I_BACK: begin
                if (r_q.cnt >= REDRV_C) r_d.st = I_OWN;
                else                    r_d.cnt = r_q.cnt + ONE_C;
            end
            default: r_d = RST_V;
        endcase
        if (!en_i) r_d = RST_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_V;
        else        r_q <= r_d;
    end

    assign oe_o    = (r_q.st == I_OWN) || (r_q.st == I_HOLD);
    assign grant_o = (r_q.st == I_OWN);
    assign hack_o  = (r_q.st == I_GNT) || (r_q.st == I_RET);

    // R4: the bus is only released in a cycle where no transfer was pending
    a_r4_release_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $fell(oe_o)) |-> $past(!pend_i));

    // R5: acknowledge only rises once the bus was already released
    a_r5_ack_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hack_o) |-> $past(!oe_o));

    // R6: acknowledge falls only after the request was low, with the bus still off
    a_r6_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hack_o) |-> ($past(!hreq_i) && !oe_o));

    // R2: a request seen while owning withdraws the grant
    a_r2_grant_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && grant_o && hreq_i) |=> !grant_o);

endmodule

// File: rtl/bown_ext_fsm.sv
module bown_ext_fsm
    import bown_pkg::*;
#(
    parameter int DRV_DLY  = 2,
    parameter int DROP_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic want_i,
    input  logic pend_i,
    input  logic hack_i,
    output logic hreq_o,
    output logic oe_o,
    output logic grant_o
);

    localparam int MAXD = max2(DRV_DLY, DROP_DLY);
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] DRV_C  = CW'(DRV_DLY);
    localparam logic [CW-1:0] DROP_C = CW'(DROP_DLY);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    typedef struct packed {
        ext_st_e       st;
        logic [CW-1:0] cnt;
    } ext_regs_t;

    localparam ext_regs_t RST_V = '{st: X_IDLE, cnt: '0};

    ext_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            X_IDLE: begin
                if (want_i && !hack_i) r_d.st = X_REQ;
            end
            X_REQ: begin
                if (hack_i) begin
                    r_d.st  = X_WAIT;
                    r_d.cnt = ONE_C;
                end
            end
            X_WAIT: begin
                if (r_q.cnt >= DRV_C) r_d.st = X_OWN;
                else                  r_d.cnt = r_q.cnt + ONE_C;
            end
            X_OWN: begin
                if (!want_i && !pend_i) begin
                    r_d.st  = X_REL;
                    r_d.cnt = ONE_C;
                end
            end
            X_REL: begin
                if (r_q.cnt >= DROP_C) r_d.st = X_IDLE;
                else                   r_d.cnt = r_q.cnt + ONE_C;
            end
            default: r_d = RST_V;
        endcase
        if (!en_i) r_d = RST_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_V;
        else        r_q <= r_d;
    end

    assign hreq_o  = (r_q.st != X_IDLE);
    assign oe_o    = (r_q.st == X_OWN);
    assign grant_o = (r_q.st == X_OWN);

    // R10: drive only starts after the acknowledge was seen
    a_r10_drive_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_o) |-> $past(hreq_o));

    // R11: the request is dropped only with the bus already tristated
    a_r11_drop_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hreq_o) |-> (!oe_o && $past(!oe_o)));

    // R9: no new request while an old acknowledge is still high
    a_r9_no_stale_req: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !hreq_o && hack_i) |=> !hreq_o);

endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl #(
    parameter int NGRP          = 4,
    parameter int REL_DLY       = 3,
    parameter int ACK_DLY       = 1,
    parameter int RET_DLY       = 3,
    parameter int REDRV_DLY     = 1,
    parameter int EXT_DRV_DLY   = 2,
    parameter int EXT_DROP_DLY  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_ext_i,
    input  logic            xfer_pend_i,
    input  logic            loc_want_i,
    input  logic            hreq_i,
    output logic            hack_o,
    output logic            hreq_o,
    input  logic            hack_i,
    output logic [NGRP-1:0] bus_oe_o,
    output logic            grant_o
);

    logic mode_d, mode_q;
    logic int_oe, int_grant, int_hack;
    logic ext_oe, ext_grant, ext_hreq;
    logic oe_sel;

    always_comb begin
        mode_d = rst_n ? mode_q : mode_ext_i;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_d;
    end

    bown_int_fsm #(
        .REL_DLY   (REL_DLY),
        .ACK_DLY   (ACK_DLY),
        .RET_DLY   (RET_DLY),
        .REDRV_DLY (REDRV_DLY)
    ) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (!mode_q),
        .hreq_i  (hreq_i),
        .pend_i  (xfer_pend_i),
        .oe_o    (int_oe),
        .grant_o (int_grant),
        .hack_o  (int_hack)
    );

    bown_ext_fsm #(
        .DRV_DLY  (EXT_DRV_DLY),
        .DROP_DLY (EXT_DROP_DLY)
    ) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (mode_q),
        .want_i  (loc_want_i),
        .pend_i  (xfer_pend_i),
        .hack_i  (hack_i),
        .hreq_o  (ext_hreq),
        .oe_o    (ext_oe),
        .grant_o (ext_grant)
    );

    always_comb begin
        oe_sel  = mode_q ? ext_oe    : int_oe;
        grant_o = mode_q ? ext_grant : int_grant;
        hack_o  = mode_q ? 1'b0      : int_hack;
        hreq_o  = mode_q ? ext_hreq  : 1'b0;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_oe
        assign bus_oe_o[g] = oe_sel;
    end

    // R7: acknowledge never coexists with local drive or grant
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        hack_o |-> (bus_oe_o == '0 && !grant_o));

    // R1: enable bits always move together
    a_r1_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o == '0) || (bus_oe_o == '1));

    // R1: the role stays fixed outside reset
    a_r1_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

endmodule

// File: tb/test_bus_own_ctrl.sv
module test_bus_own_ctrl;

    localparam int NGRP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_ext_i = 1'b0;
    logic            xfer_pend_i = 1'b0;
    logic            loc_want_i = 1'b0;
    logic            hreq_i = 1'b0;
    logic            hack_i = 1'b0;
    logic            hack_o, hreq_o, grant_o;
    logic [NGRP-1:0] bus_oe_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    bus_own_ctrl #(.NGRP(NGRP)) i_bus_own_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_ext_i  (mode_ext_i),
        .xfer_pend_i (xfer_pend_i),
        .loc_want_i  (loc_want_i),
        .hreq_i      (hreq_i),
        .hack_o      (hack_o),
        .hreq_o      (hreq_o),
        .hack_i      (hack_i),
        .bus_oe_o    (bus_oe_o),
        .grant_o     (grant_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // R7 monitor, every cycle
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            checks++;
            if (hack_o && (bus_oe_o != '0 || grant_o)) begin
                errors++;
                $display("FAIL R7: actual hack=1 oe=%0h grant=%0d expected oe=0 grant=0",
                         bus_oe_o, grant_o);
            end
        end
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic do_reset(input logic ext);
        @(negedge clk);
        rst_n = 1'b0;
        mode_ext_i = ext;
        xfer_pend_i = 1'b0;
        loc_want_i = 1'b0;
        hreq_i = 1'b0;
        hack_i = 1'b0;
        step(3);
        rst_n = 1'b1;
        mode_ext_i = ~ext;   // must be ignored after reset
        if (!ext) begin
            chk("R1 int oe",    int'(bus_oe_o), 15);
            chk("R1 int grant", int'(grant_o), 1);
            chk("R1 int hack",  int'(hack_o), 0);
        end else begin
            chk("R1 ext oe",    int'(bus_oe_o), 0);
            chk("R1 ext grant", int'(grant_o), 0);
            chk("R1 ext hreq",  int'(hreq_o), 0);
        end
    endtask

    task automatic t_int_basic();
        hack_i = 1'b1;       // R8: must have no effect
        loc_want_i = 1'b1;
        hreq_i = 1'b1;
        step();
        chk("R2 grant drop", int'(grant_o), 0);
        chk("R2 oe held",    int'(bus_oe_o), 15);
        step(2);
        chk("R3 oe before spacing", int'(bus_oe_o), 15);
        step();
        chk("R3 oe released", int'(bus_oe_o), 0);
        chk("R5 hack not yet", int'(hack_o), 0);
        step();
        chk("R5 hack raised", int'(hack_o), 1);
        chk("R8 hreq_o", int'(hreq_o), 0);
        step(3);
        chk("R6 hack held", int'(hack_o), 1);
        hreq_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R6 hack spacing", int'(hack_o), 1);
        end
        step();
        chk("R6 hack fall", int'(hack_o), 0);
        chk("R6 oe still off", int'(bus_oe_o), 0);
        step();
        chk("R6 oe back", int'(bus_oe_o), 15);
        chk("R6 grant back", int'(grant_o), 1);
        chk("R8 hreq_o idle", int'(hreq_o), 0);
        hack_i = 1'b0;
        loc_want_i = 1'b0;
    endtask

    task automatic t_int_pending();
        xfer_pend_i = 1'b1;
        hreq_i = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R4 oe held while pending", int'(bus_oe_o), 15);
        end
        xfer_pend_i = 1'b0;
        step();
        chk("R4 oe released after drain", int'(bus_oe_o), 0);
        step();
        chk("R5 hack after drain", int'(hack_o), 1);
        hreq_i = 1'b0;
        step(5);
        chk("R6 oe back after pending case", int'(bus_oe_o), 15);
    endtask

    task automatic t_ext();
        hreq_i = 1'b1;       // R12: must have no effect
        loc_want_i = 1'b1;
        step();
        chk("R9 hreq_o raised", int'(hreq_o), 1);
        chk("R12 hack_o", int'(hack_o), 0);
        step(3);
        chk("R10 no drive w/o ack", int'(bus_oe_o), 0);
        hack_i = 1'b1;
        step();
        chk("R10 oe edge a", int'(bus_oe_o), 0);
        step();
        chk("R10 oe edge a+1", int'(bus_oe_o), 0);
        step();
        chk("R10 oe driven", int'(bus_oe_o), 15);
        chk("R10 grant", int'(grant_o), 1);
        xfer_pend_i = 1'b1;
        loc_want_i = 1'b0;
        step(2);
        chk("R11 kept while pending", int'(bus_oe_o), 15);
        chk("R12 hack_o still 0", int'(hack_o), 0);
        xfer_pend_i = 1'b0;
        step();
        chk("R11 oe off", int'(bus_oe_o), 0);
        chk("R11 grant off", int'(grant_o), 0);
        chk("R11 hreq_o held", int'(hreq_o), 1);
        step();
        chk("R11 hreq_o dropped", int'(hreq_o), 0);
        loc_want_i = 1'b1;   // hack_i still high: stale
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R9 no req on stale ack", int'(hreq_o), 0);
        end
        hack_i = 1'b0;
        step();
        chk("R9 req after ack low", int'(hreq_o), 1);
        hreq_i = 1'b0;
        loc_want_i = 1'b0;
    endtask

    initial begin
        do_reset(1'b0);
        t_int_basic();
        t_int_pending();
        do_reset(1'b1);
        t_ext();
        do_reset(1'b0);
        chk("R1 mode reloads on reset", int'(hreq_o), 0);
        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule